// File: doc/BRIEF.md
# Nonvolatile Memory Programming Controller

This block is the register-side sequencer that a small microcontroller uses to program its on-chip nonvolatile storage. Software chooses one of three targets (a program-memory row, a single data-EEPROM byte or a single configuration byte), arms the operation with a write-enable bit, and launches it with a start bit. An internal cycle counter models the array programming time. When the counter runs out, the operation is committed to a behavioural memory, the start bit drops and a sticky completion flag rises.

Program-memory writes are staged. Each table-write strobe copies the table latch byte into one of 64 holding bytes, chosen by the low six pointer bits. At completion, the whole holding row is copied into the row selected by the upper pointer bits. If the erase-enable bit is set, the same start command fills the selected row or byte with ones. A start attempted without write-enable, or cut short by a warm reset, leaves a sticky error bit behind. An unlock register exists only as an address and always reads zero.

Top module: `nvm_prog_ctl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the completion flag (address 5, bit 0) reads 0, and `busy` is low.
- R2: Address 1 (unlock) reads 0x00 whatever value was written to it.
- R3: A control write with bit 0 (start) = 1 and bit 1 (write-enable) = 0, while idle, starts nothing: `busy` stays low, bit 0 reads 0, and bit 3 (error) reads 1.
- R4: A control write with start = 1 and write-enable = 1 holds `busy` and the start bit high for exactly PROG_CYC cycles. While busy, control, latch, pointer and table writes are ignored, so writing 0 to the start bit does not clear it.
- R5: When an operation finishes, the completion flag (address 5, bit 0) becomes 1. It stays 1 until software writes that address with bit 0 = 0. Writing 1 leaves it set.
- R6: A `tbl_wr` strobe stores the latch byte (address 2) into holding byte pointer[5:0]. When a program write completes (bit 5 memory-select = 1, bit 4 config-select = 0, bit 2 erase = 0), all 64 holding bytes land in row pointer[8:6] at offsets 0 to 63.
- R7: With erase = 1, memory-select = 1 and config-select = 0, completion sets every byte of row pointer[8:6] to 0xFF.
- R8: With memory-select = 0 and config-select = 0, completion writes the latch byte to data-EEPROM byte pointer[5:0].
- R9: Config-select = 1 overrides memory-select. Completion writes the latch byte to configuration byte pointer[1:0] and leaves program memory unchanged.
- R10: A `warm_rst` pulse while busy aborts the operation. Nothing is committed, `busy` drops at once, and the control register reads 0x08 (error set, every other bit clear). The completion flag is not set.
- R11: The error bit is clear-only from software. A control write with bit 3 = 0 clears it, and writing bit 3 = 1 never sets it.
- R12: Address 2 (latch), address 3 (pointer low byte), address 4 (pointer high byte) and control bits 5, 4, 2 and 1 read back the last value written while idle. Address 6 reads the byte of the selected target at the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert, synchronous release |
| warm_rst | input | 1 | Synchronous system reset that aborts any operation in flight |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| tbl_wr | input | 1 | Table-write strobe into the holding buffer |
| busy | output | 1 | Programming timer running |
| done_irq | output | 1 | Sticky completion flag |

## Verification
The main function is driven with four target selections: a full program row of distinct bytes, an erase of that same row, a single data byte, and a configuration write with memory-select also set. A wrong row index, a missed holding byte or a lost config override each shows up as a different wrong readback. The timer is measured cycle by cycle against PROG_CYC. Start is also attempted without write-enable, and an operation is aborted mid-way, to separate the two error paths from a good completion.

// File: rtl/nvm_ctl_pkg.sv
package nvm_ctl_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL   = 3'd0,
    A_UNLOCK = 3'd1,
    A_LATCH  = 3'd2,
    A_PTRL   = 3'd3,
    A_PTRH   = 3'd4,
    A_IRQ    = 3'd5,
    A_DATA   = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    TGT_DATA = 2'd0,
    TGT_PROG = 2'd1,
    TGT_CFG  = 2'd2
  } tgt_e;

  // bit 5 .. bit 0 of the control register
  typedef struct packed {
    logic mem_sel;
    logic cfg_sel;
    logic err;
    logic erase_en;
    logic wen;
    logic go;
  } ctrl_t;
endpackage

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0) && !abort;
endmodule

// File: rtl/nvm_hold_buf.sv
module nvm_hold_buf #(
  parameter int ROW_BYTES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [7:0]               wdata,
  output logic [ROW_BYTES*8-1:0]   row_o
);
  localparam int IDX_W = $clog2(ROW_BYTES);

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;
    assign hit = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= 8'hFF;
      else if (hit) byte_q <= wdata;
    end
    assign row_o[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_ctl_pkg::*;
#(
  parameter int ROW_BYTES  = 64,
  parameter int PROG_ROWS  = 8,
  parameter int DATA_BYTES = 64,
  parameter int CFG_BYTES  = 4
) (
  input  logic                   clk,
  input  logic                   commit,
  input  logic                   erase,
  input  tgt_e                   tgt,
  input  logic [PROG_AW-1:0]     paddr,
  input  logic [DATA_AW-1:0]     daddr,
  input  logic [CFG_AW-1:0]      caddr,
  input  logic [7:0]             latch,
  input  logic [ROW_BYTES*8-1:0] row_data,
  output logic [7:0]             rd_data
);
  localparam int IDX_W      = $clog2(ROW_BYTES);
  localparam int ROW_W      = $clog2(PROG_ROWS);
  localparam int PROG_AW    = IDX_W + ROW_W;
  localparam int PROG_BYTES = ROW_BYTES * PROG_ROWS;
  localparam int DATA_AW    = $clog2(DATA_BYTES);
  localparam int CFG_AW     = (CFG_BYTES < 2) ? 1 : $clog2(CFG_BYTES);

  logic [7:0] pmem [PROG_BYTES];
  logic [7:0] dmem [DATA_BYTES];
  logic [7:0] cmem [CFG_BYTES];

  logic [ROW_W-1:0] row;
  logic [7:0]       byte_val;
  assign row      = paddr[PROG_AW-1:IDX_W];
  assign byte_val = erase ? 8'hFF : latch;

  always_ff @(posedge clk) begin
    if (commit && tgt == TGT_PROG) begin
      for (int i = 0; i < ROW_BYTES; i++) begin
        pmem[{row, IDX_W'(i)}] <= erase ? 8'hFF : row_data[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit && tgt == TGT_DATA) dmem[daddr] <= byte_val;
  end

  always_ff @(posedge clk) begin
    if (commit && tgt == TGT_CFG) cmem[caddr] <= byte_val;
  end

  always_comb begin
    case (tgt)
      TGT_PROG: rd_data = pmem[paddr];
      TGT_CFG:  rd_data = cmem[caddr];
      default:  rd_data = dmem[daddr];
    endcase
  end
endmodule

// File: rtl/nvm_prog_ctl.sv
module nvm_prog_ctl
  import nvm_ctl_pkg::*;
#(
  parameter int ROW_BYTES  = 64,
  parameter int PROG_ROWS  = 8,
  parameter int DATA_BYTES = 64,
  parameter int CFG_BYTES  = 4,
  parameter int PROG_CYC   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warm_rst,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tbl_wr,
  output logic       busy,
  output logic       done_irq
);
  localparam int IDX_W   = $clog2(ROW_BYTES);
  localparam int ROW_W   = $clog2(PROG_ROWS);
  localparam int PROG_AW = IDX_W + ROW_W;
  localparam int DATA_AW = $clog2(DATA_BYTES);
  localparam int CFG_AW  = (CFG_BYTES < 2) ? 1 : $clog2(CFG_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ctrl_t       ctrl_q, ctrl_d;
  logic [7:0]  latch_q, latch_d;
  logic [15:0] ptr_q, ptr_d;
  logic        irq_q, irq_d;

  logic timer_busy, timer_done, commit;
  logic wr_ctrl, go_req, start;
  logic idle_wr;
  tgt_e tgt;
  logic [7:0] arr_rd;
  logic [ROW_BYTES*8-1:0] hold_row;

  assign idle_wr = reg_wr && !timer_busy && !warm_rst;
  assign wr_ctrl = idle_wr && (reg_addr == A_CTRL);
  assign go_req  = wr_ctrl && reg_wdata[0];
  assign start   = go_req && reg_wdata[1];
  assign commit  = timer_done && !warm_rst;

  assign tgt = ctrl_q.cfg_sel ? TGT_CFG : (ctrl_q.mem_sel ? TGT_PROG : TGT_DATA);

  always_comb begin
    ctrl_d  = ctrl_q;
    latch_d = latch_q;
    ptr_d   = ptr_q;
    irq_d   = irq_q;
    if (warm_rst) begin
      ctrl_d     = '0;
      ctrl_d.err = ctrl_q.err | timer_busy;
    end else if (commit) begin
      ctrl_d.go = 1'b0;
    end else if (wr_ctrl) begin
      ctrl_d.mem_sel  = reg_wdata[5];
      ctrl_d.cfg_sel  = reg_wdata[4];
      ctrl_d.erase_en = reg_wdata[2];
      ctrl_d.wen      = reg_wdata[1];
      ctrl_d.go       = start;
      ctrl_d.err      = (ctrl_q.err & reg_wdata[3]) | (go_req & !reg_wdata[1]);
    end
    if (idle_wr && reg_addr == A_LATCH) latch_d = reg_wdata;
    if (idle_wr && reg_addr == A_PTRL)  ptr_d[7:0]  = reg_wdata;
    if (idle_wr && reg_addr == A_PTRH)  ptr_d[15:8] = reg_wdata;
    if (commit)
      irq_d = 1'b1;
    else if (reg_wr && reg_addr == A_IRQ && !reg_wdata[0])
      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      latch_q <= 8'h00;
      ptr_q   <= 16'h0000;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      latch_q <= latch_d;
      ptr_q   <= ptr_d;
      irq_q   <= irq_d;
    end
  end

  nvm_prog_timer #(.CYC(PROG_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .abort (warm_rst),
    .busy  (timer_busy),
    .done  (timer_done)
  );

  nvm_hold_buf #(.ROW_BYTES(ROW_BYTES)) u_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (tbl_wr && !timer_busy),
    .idx   (ptr_q[IDX_W-1:0]),
    .wdata (latch_q),
    .row_o (hold_row)
  );

  nvm_array #(
    .ROW_BYTES (ROW_BYTES),
    .PROG_ROWS (PROG_ROWS),
    .DATA_BYTES(DATA_BYTES),
    .CFG_BYTES (CFG_BYTES)
  ) u_array (
    .clk      (clk),
    .commit   (commit),
    .erase    (ctrl_q.erase_en),
    .tgt      (tgt),
    .paddr    (ptr_q[PROG_AW-1:0]),
    .daddr    (ptr_q[DATA_AW-1:0]),
    .caddr    (ptr_q[CFG_AW-1:0]),
    .latch    (latch_q),
    .row_data (hold_row),
    .rd_data  (arr_rd)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, ctrl_q};
      A_LATCH: reg_rdata = latch_q;
      A_PTRL:  reg_rdata = ptr_q[7:0];
      A_PTRH:  reg_rdata = ptr_q[15:8];
      A_IRQ:   reg_rdata = {7'b0, irq_q};
      A_DATA:  reg_rdata = arr_rd;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign busy     = timer_busy;
  assign done_irq = irq_q;
endmodule

// File: rtl/nvm_prog_ctl_chk.sv
module nvm_prog_ctl_chk #(
  parameter int PROG_CYC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       warm_rst,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [1:0] wdata_lo,
  input logic [7:0] reg_rdata,
  input logic       busy,
  input logic       done_irq,
  input logic       go,
  input logic       err
);
  localparam int BW = $clog2(PROG_CYC + 2);
  logic [BW-1:0] blen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen_q <= '0;
    else if (busy) blen_q <= blen_q + 1'b1;
    else           blen_q <= '0;
  end

  assert_unlock_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd1) |-> (reg_rdata == 8'h00));

  assert_no_start_wo_wen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !busy && !warm_rst && wdata_lo == 2'b01)
    |=> (!busy && err && !go));

  assert_go_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> go);

  assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blen_q <= BW'(PROG_CYC));

  assert_irq_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(warm_rst)) |-> done_irq);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !(reg_wr && reg_addr == 3'd5 && !wdata_lo[0])) |=> done_irq);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && busy) |=> (!busy && err && !go));
endmodule

bind nvm_prog_ctl nvm_prog_ctl_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .warm_rst  (warm_rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wdata_lo  (reg_wdata[1:0]),
  .reg_rdata (reg_rdata),
  .busy      (busy),
  .done_irq  (done_irq),
  .go        (ctrl_q.go),
  .err       (ctrl_q.err)
);

// File: tb/nvm_prog_ctl_test.sv
module nvm_prog_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tbl_wr = 1'b0;
  logic       busy, done_irq;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_prog_ctl #(.PROG_CYC(PROG_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tbl_wr(tbl_wr), .busy(busy), .done_irq(done_irq)
  );

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] wd;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{3'd2, 8'h5A, 8'h5A, 4'd12},  // R12 latch
    '{3'd3, 8'h3F, 8'h3F, 4'd12},  // R12 pointer low
    '{3'd4, 8'h01, 8'h01, 4'd12},  // R12 pointer high
    '{3'd1, 8'hFF, 8'h00, 4'd2},   // R2 unlock
    '{3'd1, 8'h55, 8'h00, 4'd2},   // R2 unlock
    '{3'd0, 8'h36, 8'h36, 4'd12},  // R12 select/enable bits
    '{3'd0, 8'h08, 8'h00, 4'd11},  // R11 error not settable
    '{3'd0, 8'h00, 8'h00, 4'd12},  // R12 cleared
    '{3'd2, 8'hA5, 8'hA5, 4'd12}   // R12 latch
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tw();
    @(negedge clk);
    tbl_wr = 1'b1;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 4 * PROG_CYC && busy; n++) @(negedge clk);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check(v, 8'h00, "R1 ctrl");
    rd(3'd5, v); check(v, 8'h00, "R1 irq");
    check({7'b0, busy}, 8'h00, "R1 busy");

    foreach (VEC[i]) begin
      wr(VEC[i].addr, VEC[i].wd);
      rd(VEC[i].addr, v);
      check(v, VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // R6 fill holding row, commit to row 2
    wr(3'd4, 8'h00);
    for (int i = 0; i < 64; i++) begin
      wr(3'd3, 8'h80 | 8'(i));
      wr(3'd2, 8'(i) ^ 8'h3C);
      tw();
    end
    wr(3'd0, 8'h23);
    len = 1;
    while (busy && len < 4 * PROG_CYC) begin
      @(negedge clk);
      if (busy) len++;
    end
    check(8'(len), 8'(PROG_CYC), "R4 busy length");
    rd(3'd0, v); check(v, 8'h22, "R4 start cleared at end");
    rd(3'd5, v); check(v, 8'h01, "R5 irq set");
    for (int i = 0; i < 64; i++) begin
      wr(3'd3, 8'h80 | 8'(i));
      rd(3'd6, v); check(v, 8'(i) ^ 8'h3C, "R6 row byte");
    end

    // R5 sticky flag
    repeat (5) @(negedge clk);
    wr(3'd5, 8'h01);
    rd(3'd5, v); check(v, 8'h01, "R5 write 1 keeps flag");
    wr(3'd5, 8'h00);
    rd(3'd5, v); check(v, 8'h00, "R5 cleared");

    // R7 erase row 2, with R4 ignored writes during busy
    wr(3'd2, 8'h44);
    wr(3'd0, 8'h27);
    wr(3'd0, 8'h26);
    rd(3'd0, v); check(v, 8'h27, "R4 start not clearable");
    wr(3'd2, 8'hEE);
    rd(3'd2, v); check(v, 8'h44, "R4 latch locked");
    check({7'b0, busy}, 8'h01, "R4 busy");
    wait_idle();
    rd(3'd5, v); check(v, 8'h01, "R5 irq after erase");
    wr(3'd5, 8'h00);
    wr(3'd3, 8'h80); rd(3'd6, v); check(v, 8'hFF, "R7 erased first");
    wr(3'd3, 8'hBF); rd(3'd6, v); check(v, 8'hFF, "R7 erased last");
    wr(3'd3, 8'h9D); rd(3'd6, v); check(v, 8'hFF, "R7 erased mid");

    // R8 data EEPROM byte
    wr(3'd3, 8'h05);
    wr(3'd2, 8'h77);
    wr(3'd0, 8'h03);
    wait_idle();
    rd(3'd6, v); check(v, 8'h77, "R8 data byte");

    // R9 config override
    wr(3'd3, 8'h82);
    wr(3'd2, 8'h9C);
    wr(3'd0, 8'h33);
    wait_idle();
    rd(3'd6, v); check(v, 8'h9C, "R9 config byte");
    wr(3'd0, 8'h22);
    rd(3'd6, v); check(v, 8'hFF, "R9 program untouched");
    wr(3'd5, 8'h00);

    // R10 abort by warm reset
    wr(3'd3, 8'h05);
    wr(3'd2, 8'h11);
    wr(3'd0, 8'h03);
    repeat (3) @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    check({7'b0, busy}, 8'h00, "R10 busy dropped");
    rd(3'd0, v); check(v, 8'h08, "R10 ctrl");
    repeat (PROG_CYC + 5) @(negedge clk);
    rd(3'd5, v); check(v, 8'h00, "R10 no irq");
    rd(3'd6, v); check(v, 8'h77, "R10 no commit");

    // R11 then R3
    wr(3'd0, 8'h00);
    rd(3'd0, v); check(v, 8'h00, "R11 err cleared");
    wr(3'd0, 8'h01);
    check({7'b0, busy}, 8'h00, "R3 no busy");
    rd(3'd0, v); check(v, 8'h08, "R3 err set");
    wr(3'd0, 8'h08);
    rd(3'd0, v); check(v, 8'h08, "R11 write 1 keeps err");
    wr(3'd0, 8'h00);
    rd(3'd0, v); check(v, 8'h00, "R11 err cleared again");

    summary();
  end
endmodule